// File: doc/BRIEF.md
# NAND Flash Bus Operation Sequencer

This block runs one raw operation on an 8-bit NAND flash bus when software asks for it. An operation is built from up to six optional phases. Software first loads the opcode pair, the address words, the byte count and the strobe timing through a small register port. It then writes the operation register, whose enable bits choose the phases, whose chip-select field picks one of four chip enables and whose address-count field sets how many address bytes go out. The block then drives the command latch, address latch, write strobe, read strobe, chip enables and data bus.

The phases always run in one fixed order: first command, address bytes, write data, second command, wait for the device to report ready, read data. A phase whose enable bit is clear, or whose byte count is zero, is skipped. Every bus cycle holds its strobe low for a programmed count of clocks and then high for a shared high count. Read bytes land in a 16-byte local buffer, which also supplies the bytes for the write-data phase. A status bit tells software when the operation has finished.

Typical uses are a device reset (first command plus wait), a block erase (first command, three address bytes, second command, wait), and an identification or status read (first command, optional address, 16 read bytes).

Top module: `nand_op_seq`

## Requirements
- R1: After reset the status bit reads 1, all four chip enables and both strobes are high, the command and address latches are low, the timing register (offset 5) reads 0x375 and every buffer byte reads 0.
- R2: The operation register (offset 0) enables phases with bit 6 first command, bit 5 address, bit 4 write data, bit 3 second command, bit 2 wait for ready, bit 1 read data; enabled phases run in that order and disabled phases produce no bus cycles.
- R3: Operation register bits 8:7 select the one chip enable that is held low for the whole operation; the other three stay high.
- R4: Operation register bits 11:9 give 0 to 7 address bytes, taken least significant byte first from the low address word (offset 2) and then the high address word (offset 3), each sent with the address latch high and the command latch low.
- R5: The command register (offset 1) supplies the first opcode in bits 7:0 and the second in bits 15:8, each sent with the command latch high and the address latch low.
- R6: The timing register gives the write-strobe low count in bits 3:0, the read-strobe low count in bits 7:4 and the high count in bits 11:8; a count of 0 acts as 1, and consecutive bus cycles are separated by exactly the high count.
- R7: The wait phase lasts at least one high-count period and then continues until the ready/busy input is high; no later phase starts while it is low.
- R8: The read phase reads the count register (offset 4, bits 7:0, values above 16 act as 16) number of bytes, sampling the data bus at the end of each read-strobe low time and storing the bytes at buffer offsets 16, 17, ... in bits 7:0.
- R9: An operation whose write-data bit is clear clears the buffer when it starts; the write-data phase sends buffer bytes from the first buffer byte upward.
- R10: Status register (offset 6) bit 0 reads 0 while an operation runs and 1 when idle.
- R11: Any register or buffer write made while an operation runs is ignored, including a write to the operation register, which starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register offset; values 16 to 31 address buffer bytes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_ce_n | output | 4 | Chip enables, active low |
| nf_dq_out | output | 8 | Data bus driven value |
| nf_dq_oe | output | 1 | Data bus drive enable |
| nf_dq_in | input | 8 | Data bus sampled value |
| nf_rb | input | 1 | Ready/busy from the device, high when ready |

## Verification
The assertions take for granted that the ready/busy input is a clean synchronous level and that software only starts operations whose fields are meaningful; the wait-phase property relies on ready/busy being stable across each clock. The random stimulus keeps ready/busy high for most operations so cycle counts are exact, and only the directed wait test holds it low, releasing it at a chosen cycle. Random timing nibbles include zero so the minimum-width rule is covered, and byte counts go above 16 to reach the saturation.

// File: rtl/nand_op_seq.sv
module nand_op_seq #(
  parameter int BUF_BYTES = 16,
  parameter logic [11:0] TIMING_RST = 12'h375,
  localparam int BW = $clog2(BUF_BYTES),
  localparam int CW = BW + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [BW:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [3:0]  nf_ce_n,
  output logic [7:0]  nf_dq_out,
  output logic        nf_dq_oe,
  input  logic [7:0]  nf_dq_in,
  input  logic        nf_rb
);
  localparam logic [2:0] S_IDLE = 3'd0, S_CMD1 = 3'd1, S_ADDR = 3'd2, S_WDAT = 3'd3,
                         S_CMD2 = 3'd4, S_WAIT = 3'd5, S_RDAT = 3'd6;

  logic [2:0]    st;
  logic [11:0]   op_q;
  logic [15:0]   cmd_q;
  logic [31:0]   alo_q, ahi_q;
  logic [7:0]    cnt_q;
  logic [11:0]   tim_q;
  logic [3:0]    tcnt;
  logic          hi;
  logic [CW-1:0] idx;
  logic [7:0]    bufm [BUF_BYTES];

  logic          idle, bus_st, start;
  logic [3:0]    wl, rl, hl, low_len;
  logic [CW-1:0] neff, lim;
  logic [63:0]   a64;

  assign idle   = (st == S_IDLE);
  assign bus_st = (st == S_CMD1) || (st == S_ADDR) || (st == S_WDAT) || (st == S_CMD2) || (st == S_RDAT);
  assign start  = reg_wr && idle && (reg_addr == '0);
  assign wl     = (tim_q[3:0] == 4'd0) ? 4'd1 : tim_q[3:0];
  assign rl     = (tim_q[7:4] == 4'd0) ? 4'd1 : tim_q[7:4];
  assign hl     = (tim_q[11:8] == 4'd0) ? 4'd1 : tim_q[11:8];
  assign low_len = (st == S_RDAT) ? rl : wl;
  assign neff   = (cnt_q > 8'(BUF_BYTES)) ? CW'(BUF_BYTES) : cnt_q[CW-1:0];
  assign lim    = (st == S_ADDR) ? CW'(op_q[11:9]) :
                  ((st == S_WDAT) || (st == S_RDAT)) ? neff : CW'(1);
  assign a64    = {ahi_q, alo_q};

  function automatic logic [2:0] next_phase(input logic [2:0] s, input logic [11:0] op,
                                            input logic [CW-1:0] n);
    logic [2:0] r;
    logic ok;
    r = S_IDLE;
    for (int k = 6; k >= 1; k--) begin
      case (k)
        1:       ok = op[6];
        2:       ok = op[5] && (op[11:9] != 3'd0);
        3:       ok = op[4] && (n != '0);
        4:       ok = op[3];
        5:       ok = op[2];
        default: ok = op[1] && (n != '0);
      endcase
      if ((3'(k) > s) && ok) r = 3'(k);
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; cmd_q <= '0; alo_q <= '0; ahi_q <= '0;
      cnt_q <= '0; tim_q <= TIMING_RST; tcnt <= '0; hi <= 1'b0; idx <= '0;
      for (int i = 0; i < BUF_BYTES; i++) bufm[i] <= '0;
    end else begin
      if (idle && reg_wr) begin
        if (reg_addr[BW]) bufm[reg_addr[BW-1:0]] <= reg_wdata[7:0];
        else case (reg_addr[BW-1:0])
          0: op_q  <= reg_wdata[11:0];
          1: cmd_q <= reg_wdata[15:0];
          2: alo_q <= reg_wdata;
          3: ahi_q <= reg_wdata;
          4: cnt_q <= reg_wdata[7:0];
          5: tim_q <= reg_wdata[11:0];
          default: ;
        endcase
      end
      if (start) begin
        st <= next_phase(S_IDLE, reg_wdata[11:0], neff);
        tcnt <= '0; hi <= 1'b0; idx <= '0;
        if (!reg_wdata[4]) for (int i = 0; i < BUF_BYTES; i++) bufm[i] <= '0;
      end else if (bus_st) begin
        if (!hi) begin
          if (tcnt == low_len - 4'd1) begin
            hi <= 1'b1; tcnt <= '0;
            if (st == S_RDAT) bufm[idx[BW-1:0]] <= nf_dq_in;
          end else tcnt <= tcnt + 4'd1;
        end else if (tcnt == hl - 4'd1) begin
          hi <= 1'b0; tcnt <= '0;
          if (idx + CW'(1) == lim) begin
            idx <= '0;
            st <= next_phase(st, op_q, neff);
          end else idx <= idx + CW'(1);
        end else tcnt <= tcnt + 4'd1;
      end else if (st == S_WAIT) begin
        if (tcnt == hl - 4'd1) begin
          if (nf_rb) begin st <= next_phase(st, op_q, neff); tcnt <= '0; end
        end else tcnt <= tcnt + 4'd1;
      end
    end
  end

  assign nf_cle   = (st == S_CMD1) || (st == S_CMD2);
  assign nf_ale   = (st == S_ADDR);
  assign nf_dq_oe = bus_st && (st != S_RDAT);
  assign nf_we_n  = !(nf_dq_oe && !hi);
  assign nf_re_n  = !((st == S_RDAT) && !hi);
  assign nf_ce_n  = idle ? 4'hF : ~(4'b0001 << op_q[8:7]);

  always_comb begin
    case (st)
      S_CMD1:  nf_dq_out = cmd_q[7:0];
      S_CMD2:  nf_dq_out = cmd_q[15:8];
      S_ADDR:  nf_dq_out = a64[{idx[2:0], 3'b000} +: 8];
      S_WDAT:  nf_dq_out = bufm[idx[BW-1:0]];
      default: nf_dq_out = 8'h00;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[BW]) reg_rdata = {24'd0, bufm[reg_addr[BW-1:0]]};
    else case (reg_addr[BW-1:0])
      0: reg_rdata = {20'd0, op_q};
      1: reg_rdata = {16'd0, cmd_q};
      2: reg_rdata = alo_q;
      3: reg_rdata = ahi_q;
      4: reg_rdata = {24'd0, cnt_q};
      5: reg_rdata = {20'd0, tim_q};
      6: reg_rdata = {31'd0, idle};
      default: reg_rdata = '0;
    endcase
  end

  assert_latch_excl_R5: assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale));
  assert_ce_single_R3: assert property (@(posedge clk) disable iff (!rst_n) $countones(~nf_ce_n) <= 1);
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n) !(!nf_we_n && !nf_re_n));
  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !nf_rb) |=> (st == S_WAIT));
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && reg_wr) |=> ($stable(op_q) && $stable(cmd_q) && $stable(tim_q)));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && reg_addr == 5'd6) |-> (nf_ce_n == 4'hF && nf_we_n && nf_re_n));
endmodule

// File: tb/sim_nand_op_seq.sv
module sim_nand_op_seq;
  logic clk = 0, rst_n = 0, reg_wr = 0, nf_rb = 1;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [3:0] nf_ce_n;
  logic [7:0] nf_dq_out, nf_dq_in;

  nand_op_seq u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_ce_n(nf_ce_n), .nf_dq_out(nf_dq_out),
    .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb));

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] seedb = 8'h5A;
  logic [15:0] m_cmd;
  logic [31:0] m_alo, m_ahi;
  int m_cnt;
  logic [11:0] m_tim = 12'h375;
  logic [7:0] mbuf [16];

  // bus monitor
  int nw, nr, busy_cnt, gap_bad, curlow, hcnt, rd_idx = 0, exp_h = 3;
  bit have_prev, plow, pbusy, p_we, p_cle, p_ale;
  logic [7:0] p_dq;
  logic [3:0] ce_cap;
  logic ev_cle [32], ev_ale [32];
  logic [7:0] ev_dq [32];
  int ev_len [32], rlen [32];

  function automatic logic [7:0] pat(input int k);
    return 8'(k * 29) ^ seedb;
  endfunction
  assign nf_dq_in = pat(rd_idx);

  always @(negedge clk) begin
    bit mb, slow;
    mb = (nf_ce_n != 4'hF);
    if (mb && !pbusy) begin
      nw = 0; nr = 0; busy_cnt = 0; gap_bad = 0; have_prev = 0; curlow = 0; hcnt = 0;
      ce_cap = nf_ce_n; rd_idx = 0;
    end
    if (mb) busy_cnt++;
    slow = !nf_we_n || !nf_re_n;
    if (slow) begin
      if (!plow && have_prev && hcnt != exp_h) gap_bad++;
      curlow++; p_we = !nf_we_n; p_cle = nf_cle; p_ale = nf_ale; p_dq = nf_dq_out;
    end else if (plow) begin
      if (p_we) begin
        if (nw < 32) begin ev_cle[nw] = p_cle; ev_ale[nw] = p_ale; ev_dq[nw] = p_dq; ev_len[nw] = curlow; end
        nw++;
      end else begin
        if (nr < 32) rlen[nr] = curlow;
        nr++; rd_idx++;
      end
      curlow = 0; hcnt = 1; have_prev = 1;
    end else hcnt++;
    plow = slow; pbusy = mb;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 5'(a); #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (nf_ce_n != 4'hF && g < 20000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic check_buf(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      rd(16 + i, d);
      chk(d == {24'd0, mbuf[i]}, tag, int'(d), int'(mbuf[i]));
    end
  endtask

  task automatic do_op(input logic [11:0] opv);
    int wl, rl, hl, n, ac, ne, nre, eb;
    logic ec [32], ea [32];
    logic [7:0] ed [32];
    logic [63:0] a64;
    logic [31:0] d;
    wl = (m_tim[3:0] == 0) ? 1 : int'(m_tim[3:0]);
    rl = (m_tim[7:4] == 0) ? 1 : int'(m_tim[7:4]);
    hl = (m_tim[11:8] == 0) ? 1 : int'(m_tim[11:8]);
    exp_h = hl;
    n = (m_cnt > 16) ? 16 : m_cnt;
    ac = int'(opv[11:9]);
    a64 = {m_ahi, m_alo};
    ne = 0;
    if (opv[6]) begin ec[ne] = 1; ea[ne] = 0; ed[ne] = m_cmd[7:0]; ne++; end
    if (opv[5]) for (int i = 0; i < ac; i++) begin ec[ne] = 0; ea[ne] = 1; ed[ne] = a64[i*8 +: 8]; ne++; end
    if (opv[4]) for (int i = 0; i < n; i++) begin ec[ne] = 0; ea[ne] = 0; ed[ne] = mbuf[i]; ne++; end
    if (opv[3]) begin ec[ne] = 1; ea[ne] = 0; ed[ne] = m_cmd[15:8]; ne++; end
    nre = opv[1] ? n : 0;
    eb = ne * (wl + hl) + nre * (rl + hl) + (opv[2] ? hl : 0);
    wr(0, {20'd0, opv});
    if (eb == 0) repeat (3) @(negedge clk); else wait_idle();
    if (eb != 0) begin
      chk(nw == ne, "R2 write cycle count", nw, ne);
      for (int i = 0; i < ne && i < nw; i++) begin
        chk(ev_cle[i] == ec[i] && ev_ale[i] == ea[i], ec[i] ? "R5 latch cmd" : "R4 latch addr",
            {ev_cle[i], ev_ale[i]}, {ec[i], ea[i]});
        chk(ev_dq[i] == ed[i], ec[i] ? "R5 opcode" : (ea[i] ? "R4 address byte" : "R9 write byte"),
            ev_dq[i], ed[i]);
        chk(ev_len[i] == wl, "R6 write low width", ev_len[i], wl);
      end
      chk(nr == nre, "R8 read cycle count", nr, nre);
      for (int i = 0; i < nre && i < nr; i++) chk(rlen[i] == rl, "R6 read low width", rlen[i], rl);
      chk(busy_cnt == eb, "R7 busy length", busy_cnt, eb);
      if (!opv[2]) chk(gap_bad == 0, "R6 high gap", gap_bad, 0);
      chk(ce_cap == ~(4'b0001 << opv[8:7]), "R3 chip enable", ce_cap, ~(4'b0001 << opv[8:7]));
    end
    if (!opv[4]) for (int i = 0; i < 16; i++) mbuf[i] = 0;
    if (opv[1]) for (int i = 0; i < n; i++) mbuf[i] = pat(i);
    rd(6, d);
    chk(d[0] == 1'b1, "R10 idle after op", d[0], 1);
    check_buf("R8 R9 buffer");
  endtask

  task automatic set_cfg(input logic [15:0] c, input logic [31:0] lo, input logic [31:0] hi,
                         input int cn, input logic [11:0] t);
    m_cmd = c; m_alo = lo; m_ahi = hi; m_cnt = cn; m_tim = t;
    wr(1, {16'd0, c}); wr(2, lo); wr(3, hi); wr(4, cn); wr(5, {20'd0, t});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [11:0] opv;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mbuf[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(nf_ce_n == 4'hF && nf_we_n && nf_re_n && !nf_cle && !nf_ale, "R1 pins after reset",
        {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, 8'hFC);
    rd(5, d); chk(d == 32'h375, "R1 timing default", d, 32'h375);
    rd(6, d); chk(d[0] == 1'b1, "R1 R10 status idle", d[0], 1);
    check_buf("R1 buffer zero");

    // device reset: first command + wait, chip 1
    set_cfg(16'h00FF, 0, 0, 0, 12'h375);
    do_op(12'h044 | (12'd1 << 7));
    // erase: cmd1, 3 address bytes, cmd2, wait, chip 3, zero timing acts as 1
    set_cfg(16'hD060, 32'h00123456, 0, 0, 12'h000);
    do_op(12'h06C | (12'd3 << 7) | (12'd3 << 9));
    // identification read of 16 bytes, one address byte
    seedb = 8'hC3;
    set_cfg(16'h0090, 0, 0, 16, 12'h213);
    do_op(12'h062 | (12'd1 << 9));
    // seven address bytes reach the high word; count above 16 saturates
    set_cfg(16'h3000, 32'hA1B2C3D4, 32'h00E5F607, 25, 12'h132);
    do_op(12'h06A | (12'd7 << 9) | (12'd2 << 7));

    // R7: wait holds while ready/busy low
    nf_rb = 0; seedb = 8'h17;
    set_cfg(16'h0070, 0, 0, 2, 12'h213);
    wr(0, 32'h046 | (32'd2 << 7));
    repeat (40) @(negedge clk);
    chk(nr == 0, "R7 no read while busy", nr, 0);
    rd(6, d); chk(d[0] == 1'b0, "R10 status running", d[0], 0);
    nf_rb = 1;
    wait_idle();
    chk(nr == 2, "R7 read after ready", nr, 2);
    for (int i = 0; i < 16; i++) mbuf[i] = (i < 2) ? pat(i) : 8'h00;
    check_buf("R8 buffer after wait");

    // R11: writes while busy are ignored
    seedb = 8'h81;
    set_cfg(16'h1234, 0, 0, 16, 12'h4FF);
    wr(0, 32'h002);
    wr(1, 32'hABCD); wr(0, 32'h040); wr(16, 32'h77); wr(5, 32'h111);
    wait_idle();
    rd(1, d); chk(d == 32'h1234, "R11 cmd unchanged", d, 32'h1234);
    rd(0, d); chk(d == 32'h002, "R11 op unchanged", d, 32'h002);
    rd(5, d); chk(d == 32'h4FF, "R11 timing unchanged", d, 32'h4FF);
    rd(16, d); chk(d == {24'd0, pat(0)}, "R11 buffer unchanged", d, pat(0));
    repeat (10) @(negedge clk);
    chk(nf_ce_n == 4'hF, "R11 no second op", nf_ce_n, 4'hF);
    for (int i = 0; i < 16; i++) mbuf[i] = pat(i);

    // random operations
    for (int t = 0; t < 40; t++) begin
      seedb = 8'($urandom);
      if ($urandom % 2 == 1)
        for (int i = 0; i < 16; i++) begin mbuf[i] = 8'($urandom); wr(16 + i, {24'd0, mbuf[i]}); end
      set_cfg(16'($urandom), $urandom, $urandom, int'($urandom % 21),
              {4'($urandom % 5), 4'($urandom % 7), 4'($urandom % 7)});
      opv = {3'($urandom), 2'($urandom), 6'($urandom), 1'b0};
      do_op(opv);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule